// File: doc/BRIEF.md
# Vector Predicate Bit Sequencer

This block walks through the elements of a vector operation and gives one predicate bit for each element, in order from element 0 up to the vector length minus one. The bit comes from one of two places. In integer mode it comes from a 64-bit integer source, read with the most-significant-bit-first convention. In condition mode it comes from an array of 64 four-bit condition fields, where a 2-bit offset picks one flag bit out of the selected field.

Condition fields can be visited in two orders. The natural order maps element i straight to field i. The legacy order reverses the field numbering inside every aligned group of eight. A single start pulse captures all configuration and source data. The block then emits one element per clock with a valid strobe, and ends the sequence with a one-cycle done pulse. An issue stage that wants per-element enables uses it to turn a stored mask into a stream of element bits.

Top module: `pred_seq_top`

## Requirements
- R1: In integer mode (`use_int`=1), the predicate for element i is `int_src[63-i]`, where 0 is the least significant bit.
- R2: In condition mode with natural order (`legacy_order`=0), element i reads field i. Field j occupies `cond_flat[4j+3:4j]`.
- R3: In condition mode with legacy order (`legacy_order`=1), element i reads field (7-(i mod 8)) OR (i AND NOT 7). This gives the order 7..0, 15..8, 23..16 and so on.
- R4: Flag offset o picks bit (3-o) of the selected 4-bit field. Offset 0 gives the field's bit 3 and offset 3 gives its bit 0.
- R5: For a length L between 1 and 64, exactly L beats with `pred_valid`=1 appear in consecutive cycles with `elem_idx` = 0,1,..,L-1. The first beat follows the clock edge after the edge that accepted start.
- R6: `done` is high for exactly one cycle, in the cycle right after the last beat. It is never high together with `pred_valid`.
- R7: When the length is 0, no beat appears and `done` is high in the cycle after the edge that accepted start.
- R8: A start seen from acceptance through the cycle before `done` has no effect. The beat count and the done timing stay those of the running sequence.
- R9: Every input is captured on the edge that accepts start. Later changes to the mode, offset, order, length or source data do not alter a running sequence.
- R10: A length above 64 is treated as 64.
- R11: While reset is high and in the cycle after it is released, `pred_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence when idle |
| vec_len | input | 7 | Vector length, 0 to 64 |
| use_int | input | 1 | 1: integer source, 0: condition fields |
| flag_ofs | input | 2 | Flag bit selector within a condition field |
| legacy_order | input | 1 | 1: group-reversed field numbering |
| int_src | input | 64 | Integer predicate source |
| cond_flat | input | 256 | 64 packed 4-bit condition fields |
| elem_idx | output | 6 | Index of the current element |
| pred_bit | output | 1 | Predicate bit for `elem_idx` |
| pred_valid | output | 1 | Beat strobe |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with its defaults: 64 elements, 4-bit fields and groups of eight. With these values the full-length run of 64, the boundary lengths 0, 1, 8 and 9, and the crossing from one reversed group into the next are all directly reachable. Random runs with lengths above 64 exercise the clamp. In every run the inputs are scrambled straight after acceptance, and some runs send a second start partway through, so that both the capture rule and the rule that start is ignored while running can be seen at the ports.

// File: rtl/pred_seq_pkg.sv
package pred_seq_pkg;
  localparam int unsigned DEF_NUM_ELEM = 64;
  localparam int unsigned DEF_FLAG_W   = 4;
  localparam int unsigned DEF_GRP      = 8;

  typedef enum logic {
    SRC_COND = 1'b0,
    SRC_INT  = 1'b1
  } src_sel_e;
endpackage

// File: rtl/pred_seq_ctrl.sv
module pred_seq_ctrl #(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned VL_W     = $clog2(NUM_ELEM + 1),
  parameter int unsigned IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VL_W-1:0]  vec_len,
  output logic             accept,
  output logic             busy,
  output logic             fin,
  output logic [IDX_W-1:0] cur_idx
);
  localparam logic [VL_W-1:0] MAX_LEN = VL_W'(NUM_ELEM);

  logic            busy_q, fin_q;
  logic [VL_W-1:0] cnt_q, len_q, len_clamp;

  assign len_clamp = (vec_len > MAX_LEN) ? MAX_LEN : vec_len;
  assign accept    = start && !busy_q && !fin_q;
  assign busy      = busy_q;
  assign fin       = fin_q;
  assign cur_idx   = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else begin
      fin_q <= 1'b0;
      if (accept) begin
        len_q <= len_clamp;
        cnt_q <= '0;
        if (len_clamp == '0) fin_q  <= 1'b1;
        else                 busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q + VL_W'(1);
        if (cnt_q == len_q - VL_W'(1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < len_q)); // R5
  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    len_q <= MAX_LEN); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> $stable(len_q)); // R8
endmodule

// File: rtl/pred_field_map.sv
module pred_field_map #(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned GRP      = 8,
  parameter int unsigned IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic [IDX_W-1:0] elem,
  input  logic             legacy,
  output logic [IDX_W-1:0] field
);
  localparam logic [IDX_W-1:0] LOW_MASK = IDX_W'(GRP - 1);

  generate
    if (GRP > 1) begin : g_grouped
      logic [IDX_W-1:0] rev_idx;
      assign rev_idx = (LOW_MASK - (elem & LOW_MASK)) | (elem & ~LOW_MASK);
      assign field   = legacy ? rev_idx : elem;
    end else begin : g_flat
      logic unused_leg;
      assign unused_leg = legacy;
      assign field      = elem;
    end
  endgenerate
endmodule

// File: rtl/pred_bit_pick.sv
module pred_bit_pick #(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned FLAG_W   = 4,
  parameter int unsigned IDX_W    = $clog2(NUM_ELEM),
  parameter int unsigned OFS_W    = $clog2(FLAG_W)
) (
  input  pred_seq_pkg::src_sel_e   src,
  input  logic [OFS_W-1:0]         ofs,
  input  logic [IDX_W-1:0]         elem,
  input  logic [IDX_W-1:0]         field,
  input  logic [NUM_ELEM-1:0]      int_src,
  input  logic [NUM_ELEM*FLAG_W-1:0] cond_src,
  output logic                     bit_out
);
  localparam int unsigned POS_W = $clog2(NUM_ELEM * FLAG_W);

  logic [IDX_W-1:0] int_pos;
  logic [POS_W-1:0] cond_pos;

  assign int_pos  = IDX_W'(NUM_ELEM - 1) - elem;
  assign cond_pos = POS_W'(field) * POS_W'(FLAG_W) + POS_W'(FLAG_W - 1) - POS_W'(ofs);

  always_comb begin
    if (src == pred_seq_pkg::SRC_INT) bit_out = int_src[int_pos];
    else                              bit_out = cond_src[cond_pos];
  end
endmodule

// File: rtl/pred_seq_top.sv
module pred_seq_top #(
  parameter int unsigned NUM_ELEM = pred_seq_pkg::DEF_NUM_ELEM,
  parameter int unsigned FLAG_W   = pred_seq_pkg::DEF_FLAG_W,
  parameter int unsigned GRP      = pred_seq_pkg::DEF_GRP,
  localparam int unsigned VL_W    = $clog2(NUM_ELEM + 1),
  localparam int unsigned IDX_W   = $clog2(NUM_ELEM),
  localparam int unsigned OFS_W   = $clog2(FLAG_W)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [VL_W-1:0]            vec_len,
  input  logic                       use_int,
  input  logic [OFS_W-1:0]           flag_ofs,
  input  logic                       legacy_order,
  input  logic [NUM_ELEM-1:0]        int_src,
  input  logic [NUM_ELEM*FLAG_W-1:0] cond_flat,
  output logic [IDX_W-1:0]           elem_idx,
  output logic                       pred_bit,
  output logic                       pred_valid,
  output logic                       done
);
  import pred_seq_pkg::*;

  logic                       accept, busy, fin, pick;
  logic [IDX_W-1:0]           cur_idx, field_idx;
  src_sel_e                   src_q;
  logic [OFS_W-1:0]           ofs_q;
  logic                       leg_q;
  logic [NUM_ELEM-1:0]        int_q;
  logic [NUM_ELEM*FLAG_W-1:0] cond_q;

  pred_seq_ctrl #(.NUM_ELEM(NUM_ELEM), .VL_W(VL_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .vec_len(vec_len),
    .accept(accept), .busy(busy), .fin(fin), .cur_idx(cur_idx)
  );

  pred_field_map #(.NUM_ELEM(NUM_ELEM), .GRP(GRP), .IDX_W(IDX_W)) u_map (
    .elem(cur_idx), .legacy(leg_q), .field(field_idx)
  );

  pred_bit_pick #(.NUM_ELEM(NUM_ELEM), .FLAG_W(FLAG_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_pick (
    .src(src_q), .ofs(ofs_q), .elem(cur_idx), .field(field_idx),
    .int_src(int_q), .cond_src(cond_q), .bit_out(pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_COND;
      ofs_q  <= '0;
      leg_q  <= 1'b0;
      int_q  <= '0;
      cond_q <= '0;
    end else if (accept) begin
      src_q  <= use_int ? SRC_INT : SRC_COND;
      ofs_q  <= flag_ofs;
      leg_q  <= legacy_order;
      int_q  <= int_src;
      cond_q <= cond_flat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elem_idx   <= '0;
      pred_bit   <= 1'b0;
      pred_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      pred_valid <= busy;
      done       <= fin;
      if (busy) begin
        elem_idx <= cur_idx;
        pred_bit <= pick;
      end
    end
  end

  AST_FIRST_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(pred_valid) |-> (elem_idx == '0)); // R5
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && $past(pred_valid)) |-> (elem_idx == IDX_W'($past(elem_idx) + 1'b1))); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(pred_valid) |-> done); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    done |-> !pred_valid); // R6
endmodule

// File: tb/test_pred_seq_top.sv
module test_pred_seq_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [6:0]   vec_len = '0;
  logic         use_int = 1'b0;
  logic [1:0]   flag_ofs = '0;
  logic         legacy_order = 1'b0;
  logic [63:0]  int_src = '0;
  logic [255:0] cond_flat = '0;
  logic [5:0]   elem_idx;
  logic         pred_bit, pred_valid, done;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  pred_seq_top i_pred_seq_top (
    .clk(clk), .rst(rst), .start(start), .vec_len(vec_len), .use_int(use_int),
    .flag_ofs(flag_ofs), .legacy_order(legacy_order), .int_src(int_src),
    .cond_flat(cond_flat), .elem_idx(elem_idx), .pred_bit(pred_bit),
    .pred_valid(pred_valid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_bit(input logic [63:0] iv, input logic [255:0] cv,
                                 input bit im, input logic [1:0] o, input bit lg, input int i);
    int f;
    if (im) return iv[63 - i];
    f = lg ? ((7 - (i % 8)) | (i & ~7)) : i;
    return cv[f * 4 + 3 - o];
  endfunction

  function automatic logic [255:0] rnd_cond();
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_seq(input int vl, input bit im, input logic [1:0] o, input bit lg, input bit poke);
    logic [63:0]  ei;
    logic [255:0] ec;
    int           evl;
    string        req;
    bit           exp_b;
    evl = (vl > 64) ? 64 : vl;
    req = im ? "R1" : (lg ? "R3" : "R2");
    @(negedge clk);
    ei = {$urandom, $urandom};
    ec = rnd_cond();
    int_src = ei; cond_flat = ec; vec_len = 7'(vl);
    use_int = im; flag_ofs = o; legacy_order = lg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    int_src = ~ei; cond_flat = ~ec; use_int = !im; flag_ofs = ~o;
    legacy_order = !lg; vec_len = 7'($urandom_range(0, 64));
    for (int cyc = 1; cyc <= evl + 1; cyc++) begin
      @(negedge clk);
      if (cyc <= evl) begin
        exp_b = ref_bit(ei, ec, im, o, lg, cyc - 1);
        chk(pred_valid && !done && elem_idx == 6'(cyc - 1), "R5 beat index", longint'(elem_idx), longint'(cyc - 1));
        chk(pred_bit == exp_b, {req, " R4 R9 bit"}, longint'(pred_bit), longint'(exp_b));
      end else begin
        chk(!pred_valid && done, evl == 0 ? "R7 empty done" : "R6 done after last",
            longint'({pred_valid, done}), 64'h1);
      end
      start = (poke && cyc == 1 && evl >= 2);
    end
    @(negedge clk);
    start = 1'b0;
    chk(!pred_valid && !done, "R6 R8 done single pulse", longint'({pred_valid, done}), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lens[5];
    void'($urandom(32'd20240601));
    lens = '{0, 1, 8, 9, 64};
    repeat (2) @(negedge clk);
    chk(!pred_valid && !done, "R11 reset", longint'({pred_valid, done}), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pred_valid && !done, "R11 after reset", longint'({pred_valid, done}), 64'h0);
    foreach (lens[k]) begin
      run_seq(lens[k], 1'b1, 2'd0, 1'b0, 1'b1);
      run_seq(lens[k], 1'b0, 2'(k % 4), 1'b0, 1'b1);
      run_seq(lens[k], 1'b0, 2'((k + 1) % 4), 1'b1, 1'b0);
    end
    for (int o = 0; o < 4; o++) run_seq(16, 1'b0, 2'(o), 1'b1, 1'b0); // R4
    run_seq(100, 1'b0, 2'd2, 1'b1, 1'b1); // R10
    run_seq(127, 1'b1, 2'd1, 1'b0, 1'b0); // R10
    for (int n = 0; n < 40; n++)
      run_seq($urandom_range(0, 70), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule